// File: doc/BRIEF.md
# Flag-Handshake Asynchronous Serial Transmitter

This block serializes bytes onto an asynchronous serial line. Software places a byte in a holding register through a write strobe. The same strobe clears the data-empty flag, which tells the transmitter that a byte is waiting. When the transmitter is idle, or about to finish a stop bit, it copies the holding register into its shift register on the next bit tick and sets the empty flag again. It then sends a low start bit, the data bits with the least significant bit first, an optional parity or multiprocessor bit, and one or two high stop bits.

The empty flag is checked at the end of the last stop bit. If a byte is waiting, the next start bit follows with no idle gap. If no byte is waiting, the transmit-end flag is set and the line rests high. Two level interrupt requests follow the flags, each gated by its own enable. Bit timing comes from an external one-cycle tick, and the line state changes only on a tick.

Top module: `uart_txh`

## Requirements
- R1: After reset, txd_o is 1, empty_o is 1 and end_o is 1.
- R2: A cycle with wr_i high stores wr_data_i in the holding register and clears both empty_o and end_o in the next cycle. This also happens when a load or an end event falls in the same cycle, because the write takes priority.
- R3: With tx_en_i high, empty_o 0 and the line idle, a bit tick loads the holding register and sets empty_o to 1. txd_o then drives the start bit 0 for one tick period.
- R4: Data bits follow the start bit, least significant bit first. There are 8 of them when len7_i is 0, and 7 of them (bits 6:0, bit 7 not sent) when len7_i is 1.
- R5: par_mode_i selects the bit after the data. 0 sends no bit. 1 sends even parity and 2 sends odd parity, both counted over the sent data bits only. 3 sends the value of mpb_i as it was at load.
- R6: After the data and optional parity bit, the line sends one stop bit of 1 when stop2_i is 0, and two when stop2_i is 1.
- R7: If empty_o is 0 when the last stop bit ends, the next byte is loaded on that tick. Its start bit follows at once, and end_o stays 0.
- R8: If empty_o is 1 when the last stop bit ends, end_o goes to 1 and txd_o stays at 1 until a later start bit.
- R9: txi_o is high exactly when empty_o is 1 and txi_en_i is 1.
- R10: tei_o is high exactly when end_o is 1 and tei_en_i is 1.
- R11: While tx_en_i is 0, txd_o is 1, no load takes place and empty_o does not change from a tick.
- R12: With tx_en_i high, txd_o changes only in the cycle after a bit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmitter enable |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| wr_i | input | 1 | Write holding register and clear empty flag |
| wr_data_i | input | 8 | Byte to send |
| len7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_mode_i | input | 2 | 0 none, 1 even, 2 odd, 3 multiprocessor bit |
| mpb_i | input | 1 | Multiprocessor bit value |
| stop2_i | input | 1 | 1 selects two stop bits |
| txi_en_i | input | 1 | Data-empty interrupt enable |
| tei_en_i | input | 1 | Transmit-end interrupt enable |
| txd_o | output | 1 | Serial line, idle high |
| empty_o | output | 1 | Data-empty flag |
| end_o | output | 1 | Transmit-end flag |
| txi_o | output | 1 | Data-empty interrupt request |
| tei_o | output | 1 | Transmit-end interrupt request |

## Verification
The software write and the transmitter's load can land in the same clock, and so can the write and the end of the last stop bit. Both set and clear the same flags. The bench provokes the first case by raising wr_i and bit_tick_i in one cycle while an older byte is pending. It then requires empty_o to stay 0, the start bit to appear, and the first data bit sent to belong to the older byte. The newer byte must follow after a disable and re-enable.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_MPB  = 2'd3
  } par_mode_e;
endpackage

// File: rtl/uart_txh_flags.sv
module uart_txh_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              end_set_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o,
  output logic              end_o
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q;
  logic              end_q;

  // write wins over a same-cycle load or end event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else if (wr_i) begin
      hold_q  <= wr_data_i;
      empty_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      if (load_i)    empty_q <= 1'b1;
      if (end_set_i) end_q   <= 1'b1;
    end
  end

  assign hold_o  = hold_q;
  assign empty_o = empty_q;
  assign end_o   = end_q;
endmodule

// File: rtl/uart_txh_parity.sv
module uart_txh_parity
  import uart_txh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              len_short_i,
  input  logic [1:0]        mode_i,
  input  logic              mpb_i,
  output logic              bit_o
);
  localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] counted;
  logic              odd_ones;

  assign counted  = len_short_i ? (data_i & SHORT_MASK) : data_i;
  assign odd_ones = ^counted;

  always_comb begin
    unique case (par_mode_e'(mode_i))
      PAR_EVEN: bit_o = odd_ones;
      PAR_ODD:  bit_o = ~odd_ones;
      PAR_MPB:  bit_o = mpb_i;
      default:  bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_txh_shifter.sv
module uart_txh_shifter
  import uart_txh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              par_bit_i,
  input  logic              len_short_i,
  input  logic              par_on_i,
  input  logic              stop2_i,
  output logic              load_o,
  output logic              end_set_o,
  output logic              txd_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              last_data;
  logic              last_stop;
  logic              step;

  assign step      = en_i && tick_i;
  assign last_data = cnt_q == (len_short_i ? LAST_SHORT : LAST_LONG);
  assign last_stop = stop2_i ? (cnt_q == CNT_W'(1)) : (cnt_q == '0);

  assign load_o    = step && pend_i &&
                     ((state_q == ST_IDLE) || (state_q == ST_STOP && last_stop));
  assign end_set_o = step && !pend_i && (state_q == ST_STOP) && last_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (load_o) begin
        sh_q    <= hold_i;
        par_q   <= par_bit_i;
        cnt_q   <= '0;
        state_q <= ST_START;
      end else begin
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (last_data) begin
              cnt_q   <= '0;
              state_q <= par_on_i ? ST_PAR : ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            cnt_q   <= '0;
            state_q <= ST_STOP;
          end
          ST_STOP: begin
            if (last_stop) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    if (!en_i) begin
      txd_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_START: txd_o = 1'b0;
        ST_DATA:  txd_o = sh_q[0];
        ST_PAR:   txd_o = par_q;
        default:  txd_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uart_txh.sv
module uart_txh
  import uart_txh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              bit_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              len7_i,
  input  logic [1:0]        par_mode_i,
  input  logic              mpb_i,
  input  logic              stop2_i,
  input  logic              txi_en_i,
  input  logic              tei_en_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              end_o,
  output logic              txi_o,
  output logic              tei_o
);
  logic [DATA_W-1:0] hold;
  logic              load;
  logic              end_set;
  logic              par_bit;
  logic              par_on;

  assign par_on = par_mode_e'(par_mode_i) != PAR_NONE;

  uart_txh_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .end_set_i (end_set),
    .hold_o    (hold),
    .empty_o   (empty_o),
    .end_o     (end_o)
  );

  uart_txh_parity #(.DATA_W(DATA_W)) u_parity (
    .data_i      (hold),
    .len_short_i (len7_i),
    .mode_i      (par_mode_i),
    .mpb_i       (mpb_i),
    .bit_o       (par_bit)
  );

  uart_txh_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_i),
    .tick_i      (bit_tick_i),
    .pend_i      (!empty_o),
    .hold_i      (hold),
    .par_bit_i   (par_bit),
    .len_short_i (len7_i),
    .par_on_i    (par_on),
    .stop2_i     (stop2_i),
    .load_o      (load),
    .end_set_o   (end_set),
    .txd_o       (txd_o)
  );

  assign txi_o = empty_o && txi_en_i;
  assign tei_o = end_o && tei_en_i;
endmodule

// File: rtl/uart_txh_checker.sv
module uart_txh_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic bit_tick_i,
  input logic wr_i,
  input logic txi_en_i,
  input logic tei_en_i,
  input logic txd_o,
  input logic empty_o,
  input logic end_o,
  input logic txi_o,
  input logic tei_o
);
  a_r2_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!empty_o && !end_o));

  a_r8_end_is_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> txd_o);

  a_r9_txi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txi_o |-> (empty_o && txi_en_i));

  a_r10_tei_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tei_o |-> (end_o && tei_en_i));

  a_r11_disabled_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> txd_o);

  a_r11_no_load_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !wr_i && !empty_o) |=> !empty_o);

  a_r12_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !bit_tick_i) |=> (!tx_en_i || $stable(txd_o)));
endmodule

bind uart_txh uart_txh_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .bit_tick_i (bit_tick_i),
  .wr_i       (wr_i),
  .txi_en_i   (txi_en_i),
  .tei_en_i   (tei_en_i),
  .txd_o      (txd_o),
  .empty_o    (empty_o),
  .end_o      (end_o),
  .txi_o      (txi_o),
  .tei_o      (tei_o)
);

// File: tb/uart_txh_tb.sv
module uart_txh_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       len7_i = 1'b0;
  logic [1:0] par_mode_i = '0;
  logic       mpb_i = 1'b0;
  logic       stop2_i = 1'b0;
  logic       txi_en_i = 1'b0;
  logic       tei_en_i = 1'b0;
  logic       txd_o, empty_o, end_o, txi_o, tei_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_txh u_dut (.*);

  // {data[7:0], len7, par_mode[1:0], mpb, stop2}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {8'hA5, 1'b0, 2'd1, 1'b0, 1'b0},
    {8'h3C, 1'b0, 2'd2, 1'b0, 1'b1},
    {8'hFF, 1'b1, 2'd0, 1'b0, 1'b0},
    {8'h81, 1'b1, 2'd1, 1'b0, 1'b1},
    {8'h5A, 1'b0, 2'd3, 1'b1, 1'b0},
    {8'h00, 1'b0, 2'd2, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk_i);
    bit_tick_i = 1'b1;
    @(negedge clk_i);
    bit_tick_i = 1'b0;
  endtask

  // frame bits after the idle line, index 0 is the start bit
  function automatic int build(input logic [12:0] v, output logic [15:0] f);
    logic [7:0] d;
    int n, nd;
    logic ones;
    d = v[12:5];
    nd = v[4] ? 7 : 8;
    f = '1;
    f[0] = 1'b0;
    n = 1;
    ones = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[n] = d[i];
      ones ^= d[i];
      n++;
    end
    case (v[3:2])
      2'd1: begin f[n] = ones;  n++; end
      2'd2: begin f[n] = ~ones; n++; end
      2'd3: begin f[n] = v[1];  n++; end
      default: ;
    endcase
    n += v[0] ? 2 : 1;
    return n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] fr;
    int len;
    logic b0;
    bit ok_frame, ok_hold;

    repeat (3) @(negedge clk_i);
    // R1 reset state, enables off
    check(txd_o && empty_o && end_o, "R1 reset txd/empty/end", {txd_o, empty_o, end_o}, 3'b111);
    check(!txi_o && !tei_o, "R9 R10 irq off with enables 0", {txi_o, tei_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    txi_en_i = 1'b1;
    tei_en_i = 1'b1;
    tx_en_i = 1'b1;
    @(negedge clk_i);
    check(txi_o && tei_o, "R9 R10 irq follow flags", {txi_o, tei_o}, 2'b11);

    // table-driven frames
    for (int v = 0; v < NV; v++) begin
      len = build(VEC[v], fr);
      len7_i = VEC[v][4];
      par_mode_i = VEC[v][3:2];
      mpb_i = VEC[v][1];
      stop2_i = VEC[v][0];
      do_write(VEC[v][12:5]);
      check(!empty_o && !end_o && !tei_o && !txi_o, "R2 write clears flags",
            {empty_o, end_o, tei_o, txi_o}, 0);
      ok_frame = 1'b1;
      ok_hold = 1'b1;
      for (int i = 0; i < len; i++) begin
        do_tick();
        if (i == 0)
          check(empty_o && txi_o && !txd_o, "R3 load sets empty, start bit",
                {empty_o, txi_o, txd_o}, 3'b110);
        if (txd_o !== fr[i]) begin
          ok_frame = 1'b0;
          $display("FAIL R4 R5 R6 vec %0d bit %0d actual=%0b expected=%0b", v, i, txd_o, fr[i]);
        end
        b0 = txd_o;
        repeat (2) @(negedge clk_i);
        if (txd_o !== b0) ok_hold = 1'b0;
      end
      check(ok_frame, "R4 R5 R6 frame bits", v, v);
      check(ok_hold, "R12 line steady between ticks", ok_hold, 1);
      do_tick();
      check(end_o && tei_o && txd_o, "R8 R10 end after last stop",
            {end_o, tei_o, txd_o}, 3'b111);
      do_tick();
      check(end_o && txd_o && empty_o, "R8 line stays mark", {end_o, txd_o, empty_o}, 3'b111);
    end

    // R7 back to back: 8 bits, no parity, one stop (10 bits)
    len7_i = 1'b0; par_mode_i = 2'd0; stop2_i = 1'b0;
    do_write(8'h11);
    do_tick();
    do_write(8'h22);
    for (int i = 1; i < 10; i++) do_tick();
    check(txd_o && !empty_o, "R7 stop bit with byte pending", {txd_o, empty_o}, 2'b10);
    do_tick();
    check(!txd_o && empty_o && !end_o, "R7 next start without gap",
          {txd_o, empty_o, end_o}, 3'b010);
    do_tick();
    check(txd_o == 1'b0, "R7 second byte bit0", txd_o, 0);
    for (int i = 2; i < 11; i++) do_tick();
    check(end_o && txd_o, "R7 R8 end after second frame", {end_o, txd_o}, 2'b11);

    // R2 collision: write and load in the same cycle
    do_write(8'h0F);
    @(negedge clk_i);
    wr_i = 1'b1; wr_data_i = 8'hF0; bit_tick_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; bit_tick_i = 1'b0;
    check(!empty_o && !txd_o && !end_o, "R2 write wins over load",
          {empty_o, txd_o, end_o}, 3'b000);
    do_tick();
    check(txd_o == 1'b1, "R2 older byte is sent", txd_o, 1);

    // R11 disable mid-frame, pending byte must stay pending
    @(negedge clk_i);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    check(txd_o == 1'b1, "R11 disabled line high", txd_o, 1);
    do_tick();
    do_tick();
    check(!empty_o && txd_o, "R11 no load while disabled", {empty_o, txd_o}, 2'b01);
    tx_en_i = 1'b1;
    do_tick();
    check(empty_o && !txd_o, "R3 load after enable", {empty_o, txd_o}, 2'b10);
    do_tick();
    check(txd_o == 1'b0, "R4 newer byte bit0", txd_o, 0);
    for (int i = 0; i < 20 && !end_o; i++) do_tick();
    check(end_o && txd_o, "R8 drained", {end_o, txd_o}, 2'b11);

    // R9 R10 enables gate the requests
    txi_en_i = 1'b0; tei_en_i = 1'b0;
    @(negedge clk_i);
    check(!txi_o && !tei_o, "R9 R10 enables off", {txi_o, tei_o}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule